// File: doc/BRIEF.md
# Floating-Point Register Producer Tag Table

This block keeps the architectural state of four floating-point registers for an out-of-order floating-point unit. Each register entry holds a data value and a small state machine with two states: `SLOT_READY` (the value is current) and `SLOT_WAIT` (a named producer, a reservation station or a load buffer, will deliver the next value). While an entry is waiting it stores that producer's tag.

On every cycle two combinational read ports return, for the registers they select, either the current value or the tag of the pending producer. Read port A also names the sink of a dispatch, because a two-operand instruction uses its first register as both source and destination. When `disp_valid` and `disp_sink_en` are high, the register on port A moves to `SLOT_WAIT` with the dispatched tag. A later dispatch to the same register replaces the tag, so only the newest producer can update the register. This removes write-after-write and write-after-read hazards without a rename pool. The result bus carries a tag and a value. Every waiting register whose tag equals the bus tag takes the value and becomes ready.

Entry transitions are named as follows. `T_CLAIM` is `SLOT_READY` to `SLOT_WAIT` on a dispatch to that sink. `T_RETARGET` is `SLOT_WAIT` to `SLOT_WAIT` with a new tag on a dispatch. `T_RESOLVE` is `SLOT_WAIT` to `SLOT_READY` on a matching broadcast. `T_HOLD` is every other cycle.

Top module: `fp_tag_table`

## Requirements
- R1: After reset every register is in `SLOT_READY` with value 0 and tag 0.
- R2: A read of a ready register returns ready=1, its value, and tag 0 in the same cycle.
- R3: A dispatch with `disp_valid`=1 and `disp_sink_en`=1 puts the register on `disp_reg_a` into `SLOT_WAIT` with `disp_tag`, which must be nonzero, from the next cycle. A read of that register then returns ready=0, value 0 and that tag.
- R4: Reads on either port during a dispatch cycle show the register state from before that cycle's sink update.
- R5: A bus broadcast (`bus_valid`=1) whose tag equals a waiting register's tag writes `bus_value` into the register, clears its tag to 0 and makes it ready in the next cycle. This applies to every register waiting on that tag.
- R6: A broadcast whose tag differs from a waiting register's tag leaves that register waiting, with its tag and value unchanged. This includes the tag of an overwritten earlier producer.
- R7: A dispatch to a register that is already waiting replaces its tag with the new one.
- R8: If a dispatch to a register and a broadcast matching its old tag occur in the same cycle, the register ends waiting on the new tag and its value is unchanged.
- R9: A read of a waiting register whose tag equals the tag of the current valid broadcast returns ready=1 and `bus_value` in that same cycle.
- R10: A dispatch with `disp_valid`=0 or with `disp_sink_en`=0 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | A dispatch is presented this cycle |
| disp_sink_en | input | 1 | The dispatch writes the register on port A |
| disp_reg_a | input | IDX_W | Register for read port A and dispatch sink |
| disp_reg_b | input | IDX_W | Register for read port B |
| disp_tag | input | TAG_W | Producer tag given to the sink (nonzero) |
| bus_valid | input | 1 | Result bus carries a broadcast |
| bus_tag | input | TAG_W | Tag of the broadcasting producer |
| bus_value | input | DATA_W | Broadcast result value |
| src_a_ready | output | 1 | Port A returns a value |
| src_a_value | output | DATA_W | Port A value (0 when waiting) |
| src_a_tag | output | TAG_W | Port A producer tag (0 when ready) |
| src_b_ready | output | 1 | Port B returns a value |
| src_b_value | output | DATA_W | Port B value (0 when waiting) |
| src_b_tag | output | TAG_W | Port B producer tag (0 when ready) |

## Verification
The bench builds the block with four registers, 16-bit data and 3-bit tags. That gives seven producer tags, enough to keep several distinct producers live at once, to let two registers wait on the same tag, and to replay a stale tag after it has been overwritten. With the narrow data width, each broadcast value stays easy to tell apart. With four registers, every read-port index and every sink index is exercised.

// File: rtl/fp_tag_pkg.sv
package fp_tag_pkg;
    typedef enum logic {
        SLOT_READY = 1'b0,
        SLOT_WAIT  = 1'b1
    } slot_state_e;
endpackage

// File: rtl/fp_tag_slot.sv
module fp_tag_slot
    import fp_tag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              claim,
    input  logic [TAG_W-1:0]  claim_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_value,
    output slot_state_e       state_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [DATA_W-1:0] value_o
);
    slot_state_e       state_q, state_d;
    logic [TAG_W-1:0]  tag_q, tag_d;
    logic [DATA_W-1:0] val_q, val_d;
    logic              hit;

    assign hit = bus_valid && (bus_tag != '0) && (state_q == SLOT_WAIT) && (bus_tag == tag_q);

    // next-state process: T_CLAIM, T_RETARGET, T_RESOLVE, T_HOLD
    always_comb begin
        state_d = state_q;
        tag_d   = tag_q;
        val_d   = val_q;
        unique case (state_q)
            SLOT_READY: begin
                if (claim) begin            // T_CLAIM
                    state_d = SLOT_WAIT;
                    tag_d   = claim_tag;
                end
            end
            SLOT_WAIT: begin
                if (claim) begin            // T_RETARGET (newest producer wins)
                    state_d = SLOT_WAIT;
                    tag_d   = claim_tag;
                end else if (hit) begin     // T_RESOLVE
                    state_d = SLOT_READY;
                    tag_d   = '0;
                    val_d   = bus_value;
                end
            end
            default: begin
                state_d = SLOT_READY;
                tag_d   = '0;
            end
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_READY;
            tag_q   <= '0;
            val_q   <= '0;
        end else begin
            state_q <= state_d;
            tag_q   <= tag_d;
            val_q   <= val_d;
        end
    end

    assign state_o = state_q;
    assign tag_o   = tag_q;
    assign value_o = val_q;

    assert_claim_sets_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        claim |=> (state_q == SLOT_WAIT) && (tag_q == $past(claim_tag)));

    assert_retarget_keeps_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        claim |=> $stable(val_q));

    assert_hit_resolves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !claim) |=> (state_q == SLOT_READY) && (tag_q == '0) && (val_q == $past(bus_value)));

    assert_miss_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_WAIT && !hit && !claim) |=> (state_q == SLOT_WAIT) && $stable(tag_q) && $stable(val_q));

    assert_ready_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_READY && !claim) |=> (state_q == SLOT_READY) && $stable(val_q));
endmodule

// File: rtl/fp_src_port.sv
module fp_src_port
    import fp_tag_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32,
    parameter int TAG_W    = 3,
    parameter int IDX_W    = 2
) (
    input  logic [IDX_W-1:0]  sel,
    input  slot_state_e       states [NUM_REGS],
    input  logic [TAG_W-1:0]  tags   [NUM_REGS],
    input  logic [DATA_W-1:0] vals   [NUM_REGS],
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_value,
    output logic              ready,
    output logic [DATA_W-1:0] value,
    output logic [TAG_W-1:0]  tag
);
    always_comb begin
        ready = 1'b1;
        value = '0;
        tag   = '0;
        if (int'(sel) < NUM_REGS) begin
            if (states[sel] == SLOT_READY) begin
                value = vals[sel];
            end else if (bus_valid && (bus_tag != '0) && (bus_tag == tags[sel])) begin
                value = bus_value;          // same-cycle forward from the result bus
            end else begin
                ready = 1'b0;
                tag   = tags[sel];
            end
        end
    end
endmodule

// File: rtl/fp_tag_table.sv
module fp_tag_table
    import fp_tag_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32,
    parameter int TAG_W    = 3,
    parameter int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic              disp_sink_en,
    input  logic [IDX_W-1:0]  disp_reg_a,
    input  logic [IDX_W-1:0]  disp_reg_b,
    input  logic [TAG_W-1:0]  disp_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_value,
    output logic              src_a_ready,
    output logic [DATA_W-1:0] src_a_value,
    output logic [TAG_W-1:0]  src_a_tag,
    output logic              src_b_ready,
    output logic [DATA_W-1:0] src_b_value,
    output logic [TAG_W-1:0]  src_b_tag
);
    slot_state_e       slot_state [NUM_REGS];
    logic [TAG_W-1:0]  slot_tag   [NUM_REGS];
    logic [DATA_W-1:0] slot_val   [NUM_REGS];
    logic              claim      [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        assign claim[i] = disp_valid && disp_sink_en && (int'(disp_reg_a) == i);

        fp_tag_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .claim     (claim[i]),
            .claim_tag (disp_tag),
            .bus_valid (bus_valid),
            .bus_tag   (bus_tag),
            .bus_value (bus_value),
            .state_o   (slot_state[i]),
            .tag_o     (slot_tag[i]),
            .value_o   (slot_val[i])
        );
    end

    fp_src_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_port_a (
        .sel       (disp_reg_a),
        .states    (slot_state),
        .tags      (slot_tag),
        .vals      (slot_val),
        .bus_valid (bus_valid),
        .bus_tag   (bus_tag),
        .bus_value (bus_value),
        .ready     (src_a_ready),
        .value     (src_a_value),
        .tag       (src_a_tag)
    );

    fp_src_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_port_b (
        .sel       (disp_reg_b),
        .states    (slot_state),
        .tags      (slot_tag),
        .vals      (slot_val),
        .bus_valid (bus_valid),
        .bus_tag   (bus_tag),
        .bus_value (bus_value),
        .ready     (src_b_ready),
        .value     (src_b_value),
        .tag       (src_b_tag)
    );

    assert_wait_has_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !src_a_ready |-> (src_a_tag != '0) && (src_a_value == '0));

    assert_forward_on_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_tag != '0 && !src_b_ready) |-> (src_b_tag != bus_tag));

    assert_ready_tag_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        src_b_ready |-> (src_b_tag == '0));

    assert_sink_waits_after_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_sink_en) |=> (int'(disp_reg_a) != int'($past(disp_reg_a))) || !src_a_ready
            || (bus_valid && bus_tag == $past(disp_tag)));
endmodule

// File: tb/fp_tag_table_tb.sv
module fp_tag_table_tb;
    localparam int NR = 4;
    localparam int DW = 16;
    localparam int TW = 3;
    localparam int IW = 2;

    typedef struct {
        int          port;
        logic        rdy;
        logic [DW-1:0] val;
        logic [TW-1:0] tag;
        string       req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_valid = 0, disp_sink_en = 0, bus_valid = 0;
    logic [IW-1:0] disp_reg_a = '0, disp_reg_b = '0;
    logic [TW-1:0] disp_tag = '0, bus_tag = '0;
    logic [DW-1:0] bus_value = '0;
    logic src_a_ready, src_b_ready;
    logic [DW-1:0] src_a_value, src_b_value;
    logic [TW-1:0] src_a_tag, src_b_tag;

    int tests = 0, fails = 0;
    bit done = 0;
    exp_t sbq[$];
    event sample_ev;

    logic          m_busy [NR];
    logic [TW-1:0] m_tag  [NR];
    logic [DW-1:0] m_val  [NR];

    always #5 clk = ~clk;

    fp_tag_table #(.NUM_REGS(NR), .DATA_W(DW), .TAG_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_sink_en(disp_sink_en),
        .disp_reg_a(disp_reg_a), .disp_reg_b(disp_reg_b), .disp_tag(disp_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value),
        .src_a_ready(src_a_ready), .src_a_value(src_a_value), .src_a_tag(src_a_tag),
        .src_b_ready(src_b_ready), .src_b_value(src_b_value), .src_b_tag(src_b_tag)
    );

    // monitor: pops expected items and compares with the read ports
    initial begin
        forever begin
            @(sample_ev);
            #1;
            while (sbq.size() > 0) begin
                exp_t e;
                logic r;
                logic [DW-1:0] v;
                logic [TW-1:0] t;
                e = sbq.pop_front();
                r = (e.port == 0) ? src_a_ready : src_b_ready;
                v = (e.port == 0) ? src_a_value : src_b_value;
                t = (e.port == 0) ? src_a_tag   : src_b_tag;
                tests++;
                if (r !== e.rdy || v !== e.val || t !== e.tag) begin
                    fails++;
                    $display("FAIL %s port%0d: got rdy=%0b val=%h tag=%0d, expected rdy=%0b val=%h tag=%0d",
                             e.req, e.port, r, v, t, e.rdy, e.val, e.tag);
                end
            end
        end
    end

    // expected read of register idx under the current bus inputs
    function automatic exp_t model_read(int port, int idx, string req);
        exp_t e;
        e.port = port; e.req = req;
        if (!m_busy[idx]) begin
            e.rdy = 1; e.val = m_val[idx]; e.tag = '0;
        end else if (bus_valid && bus_tag != '0 && bus_tag == m_tag[idx]) begin
            e.rdy = 1; e.val = bus_value; e.tag = '0;
        end else begin
            e.rdy = 0; e.val = '0; e.tag = m_tag[idx];
        end
        return e;
    endfunction

    task automatic fire();
        -> sample_ev;
        #3;
    endtask

    // one cycle: drive at negedge, check reads before the edge, update model
    task automatic step(input logic dv, input logic se, input int a, input int b,
                        input int t, input logic bv, input int bt, input logic [DW-1:0] bval,
                        input string req);
        disp_valid = dv; disp_sink_en = se;
        disp_reg_a = IW'(a); disp_reg_b = IW'(b); disp_tag = TW'(t);
        bus_valid = bv; bus_tag = TW'(bt); bus_value = bval;
        sbq.push_back(model_read(0, a, req));
        sbq.push_back(model_read(1, b, req));
        fire();
        @(posedge clk);
        for (int i = 0; i < NR; i++) begin
            if (dv && se && a == i) begin
                m_busy[i] = 1; m_tag[i] = TW'(t);
            end else if (m_busy[i] && bv && TW'(bt) != '0 && TW'(bt) == m_tag[i]) begin
                m_busy[i] = 0; m_tag[i] = '0; m_val[i] = bval;
            end
        end
        @(negedge clk);
        disp_valid = 0; disp_sink_en = 0; bus_valid = 0;
    endtask

    task automatic check_all(input string req);
        bus_valid = 0; disp_valid = 0;
        for (int i = 0; i < NR; i++) begin
            disp_reg_a = IW'(i);
            disp_reg_b = IW'((i + 1) % NR);
            sbq.push_back(model_read(0, i, req));
            sbq.push_back(model_read(1, (i + 1) % NR, req));
            fire();
        end
    endtask

    initial begin
        for (int i = 0; i < NR; i++) begin
            m_busy[i] = 0; m_tag[i] = '0; m_val[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R1 reset state / R2 ready read");

        // load each register through a claim and a broadcast (R3, R5)
        for (int i = 0; i < NR; i++) begin
            step(1, 1, i, i, i + 1, 0, 0, '0, "R4 dispatch-cycle read");
            check_all("R3 sink waits on tag");
            step(0, 0, i, (i + 1) % NR, 0, 1, i + 1, DW'(16'h1000 + 16'h0111 * i), "R9 forward");
        end
        check_all("R5 resolve / R2 ready read");

        // two registers waiting on one tag (R5)
        step(1, 1, 2, 3, 3, 0, 0, '0, "R4 read before claim");
        step(1, 1, 3, 2, 3, 0, 0, '0, "R4 read before claim");
        check_all("R3 both wait on tag 3");
        step(0, 0, 0, 1, 0, 1, 3, 16'hBEEF, "R5 broadcast cycle");
        check_all("R5 shared tag resolves all");

        // overwrite and stale broadcast (R7, R6)
        step(1, 1, 1, 0, 4, 0, 0, '0, "R4 two-operand read");
        step(1, 1, 1, 1, 5, 0, 0, '0, "R4 read old tag on retarget");
        check_all("R7 newest tag");
        step(0, 0, 1, 1, 0, 1, 4, 16'hDEAD, "R6 stale tag no forward");
        check_all("R6 stale broadcast ignored");
        step(0, 0, 1, 2, 0, 1, 5, 16'h5A5A, "R9 forward newest");
        check_all("R5 newest producer resolves");

        // claim and matching broadcast in one cycle (R8)
        step(1, 1, 0, 0, 2, 0, 0, '0, "R4 read before claim");
        step(1, 1, 0, 3, 6, 1, 2, 16'h7777, "R8 same-cycle read");
        check_all("R8 new tag wins");

        // forward on read in broadcast cycle (R9), then resolve
        step(0, 0, 0, 0, 0, 1, 6, 16'h6666, "R9 forward both ports");
        check_all("R5 after forward");

        // dispatch without valid or without sink enable (R10)
        step(0, 1, 2, 3, 7, 0, 0, '0, "R10 no valid");
        check_all("R10 no change without valid");
        step(1, 0, 2, 3, 7, 0, 0, '0, "R10 no sink");
        check_all("R10 no change without sink enable");

        // broadcast with no waiter leaves ready registers alone (R6)
        step(0, 0, 1, 2, 0, 1, 7, 16'hFFFF, "R6 unmatched broadcast");
        check_all("R6 ready registers unchanged");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule